// File: doc/BRIEF.md
# USB Packet Receive Deserializer

This block sits between a line front end and a link-layer controller. The front end has already recovered bit timing. It presents one sampled line level per bit, qualified by a bit strobe, and marks the end of each packet with a separate strobe. The deserializer finds the start-of-packet pattern and undoes the NRZI line coding. It then drops the inserted stuff bits and packs the payload into 16-bit words. It can also verify the packet CRC.

The first byte after the start pattern is the packet identifier. Its two low bits choose the CRC: the short 5-bit code for token packets, the 16-bit code for data packets, or no check at all. CRC failures are reported on their own output. Framing faults, such as a bad stuff bit or a packet that stops mid-byte, go to a general receive-error output. A packet with an odd byte count delivers its last byte in a word flagged as half full. All outputs are registered and run in the bit-strobe clock domain.

Top module: `usb_rx_deser`

## Requirements
- R1: Line level 1 is the idle (J) state. A decoded bit is 1 when the sampled level equals the previous sampled level and 0 when it differs. The previous level is taken as 1 after reset and after every end-of-packet strobe.
- R2: A packet begins when the last eight decoded bits, oldest first, are seven 0s followed by a 1. `rx_active` rises on the clock after that final bit. It stays high until the clock after the end-of-packet strobe, or after an abort. `bit_vld` and `eop` are never high together.
- R3: Inside a packet, after six consecutive decoded 1s the next strobed bit is removed as a stuff bit. The run count starts at zero after the start pattern and restarts after each stuff bit.
- R4: If a bit in the stuff position decodes as 1, `rx_err` pulses for one cycle and `rx_active` falls on the same clock. The partial word is discarded and all bits are ignored until the end-of-packet strobe.
- R5: Payload bits are packed LSB first, starting with the identifier byte. The first byte of each pair lands in bits [7:0] and the second in [15:8]. `word_vld` pulses for one cycle on the clock after the 16th bit of a word, with `word_half` low.
- R6: If exactly 8 bits are pending when the end-of-packet strobe arrives, a word with those bits in [7:0] and zeros in [15:8] is emitted. It comes with `word_vld` and `word_half` both high, on the same clock on which `rx_active` falls.
- R7: If the number of unstuffed bits at the end-of-packet strobe is not a multiple of 8, `rx_err` pulses on the next clock. No partial word is emitted and `crc_err` stays low.
- R8: With checking on, an identifier whose bits [1:0] are 01 selects CRC5 (x^5+x^2+1). Bits [1:0] equal to 11 select CRC16 (x^16+x^15+x^2+1). Either code is computed over all bits after the identifier, with the register preset to all ones. A packet passes when the final register equals 01100 for CRC5 or 0x800D for CRC16. Any other identifier is never checked.
- R9: `crc_err` can only be raised when `crc_en` is high in the cycle of the end-of-packet strobe.
- R10: `crc_err` pulses for exactly one cycle, on the clock after the end-of-packet strobe, and never in the same cycle as `rx_err`.
- R11: While `rst` is high and on the first clock after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-strobe and parallel-bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe qualifying `line_lvl` for one bit |
| line_lvl | input | 1 | Sampled line level, 1 = J |
| eop | input | 1 | End-of-packet strobe from the front end |
| crc_en | input | 1 | Enables CRC checking at packet end |
| rx_active | output | 1 | High for the duration of a received packet |
| word_vld | output | 1 | Qualifies `word_data` for one cycle |
| word_data | output | 16 | Packed received data |
| word_half | output | 1 | Only bits [7:0] of this word are valid |
| rx_err | output | 1 | Stuff or byte-alignment fault |
| crc_err | output | 1 | CRC check failed |

## Verification
The assertions assume the front end never raises the end-of-packet strobe in a cycle that also carries a bit. They also assume the line returns to idle before a new start pattern. The bench builds each packet as a list of decoded bits and encodes it with a stuffing pass and an NRZI pass. It inserts idle cycles between strobes and pulses the end-of-packet strobe only on a cycle with no bit. It starts every packet from the idle level, so it stays inside these assumptions. Token fields, data payload lengths, CRC enable and deliberate corruption are swept. Dedicated packets cover a bad stuff bit and stops off the byte boundary.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2
  } rx_state_e;

  localparam int          BYTE_W     = 8;
  localparam int          WORD_W     = 2 * BYTE_W;
  localparam logic [1:0]  KIND_TOKEN = 2'b01;
  localparam logic [1:0]  KIND_DATA  = 2'b11;
  localparam logic [4:0]  C5_POLY    = 5'b00101;
  localparam logic [4:0]  C5_RESID   = 5'b01100;
  localparam logic [15:0] C16_POLY   = 16'h8005;
  localparam logic [15:0] C16_RESID  = 16'h800D;
endpackage

// File: rtl/urx_line_decode.sv
module urx_line_decode #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic in_vld,
  input  logic in_lvl,
  input  logic count_en,
  output logic raw_bit,
  output logic dat_vld,
  output logic stuff_err
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN);

  logic          prev_q;
  logic [CW-1:0] ones_q;
  logic          at_stuff;

  assign raw_bit   = (in_lvl == prev_q);
  assign at_stuff  = count_en && (ones_q == RUN_MAX);
  assign dat_vld   = in_vld && count_en && !at_stuff;
  assign stuff_err = in_vld && at_stuff && raw_bit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      prev_q <= 1'b1;
      ones_q <= '0;
    end else if (in_vld) begin
      prev_q <= in_lvl;
      if (!count_en || at_stuff || !raw_bit) ones_q <= '0;
      else                                   ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/urx_sync_hunt.sv
module urx_sync_hunt #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_vld,
  input  logic bit_in,
  output logic found
);
  localparam logic [LEN-1:0] PAT = LEN'(1);

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] nxt;

  assign nxt   = {sh_q[LEN-2:0], bit_in};
  assign found = en && bit_vld && (nxt == PAT);

  always_ff @(posedge clk) begin
    if (rst || clr)          sh_q <= '1;
    else if (en && bit_vld)  sh_q <= nxt;
  end
endmodule

// File: rtl/urx_crc_serial.sv
module urx_crc_serial #(
  parameter int             W     = 5,
  parameter logic [W-1:0]   POLY  = '0,
  parameter logic [W-1:0]   RESID = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic ok
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = bit_in ^ crc_q[W-1];
  assign ok = (crc_q == RESID);

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '1;
    else if (en)    crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/urx_word_pack.sv
module urx_word_pack #(
  parameter int BW = 8,
  parameter int DW = 2 * BW,
  localparam int FW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          flush,
  output logic [DW-1:0] word_q,
  output logic          vld_q,
  output logic          half_q,
  output logic [FW-1:0] fill_q
);
  localparam logic [FW-1:0] LAST = FW'(DW - 1);
  localparam logic [FW-1:0] HALF = FW'(BW);

  logic [DW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      half_q <= 1'b0;
      fill_q <= '0;
    end else begin
      vld_q  <= 1'b0;
      half_q <= 1'b0;
      if (clr) begin
        fill_q <= '0;
      end else if (bit_vld) begin
        acc_q[fill_q] <= bit_in;
        if (fill_q == LAST) begin
          word_q <= {bit_in, acc_q[DW-2:0]};
          vld_q  <= 1'b1;
          fill_q <= '0;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end else if (flush && fill_q == HALF) begin
        word_q <= {{(DW-BW){1'b0}}, acc_q[BW-1:0]};
        vld_q  <= 1'b1;
        half_q <= 1'b1;
        fill_q <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
  import usb_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  parameter int SYNC_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              line_lvl,
  input  logic              eop,
  input  logic              crc_en,
  output logic              rx_active,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              word_half,
  output logic              rx_err,
  output logic              crc_err
);
  localparam int FW = $clog2(WORD_W);
  localparam int PW = $clog2(BYTE_W + 1);
  localparam logic [PW-1:0] PID_DONE = PW'(BYTE_W);
  localparam logic [FW-1:0] FILL_MID = FW'(BYTE_W);

  rx_state_e      state_q;
  logic           recv;
  logic           raw_bit, dat_vld, stuff_err, sync_found;
  logic [7:0]     pid_q;
  logic [PW-1:0]  pid_cnt_q;
  logic           pid_full;
  logic           c5_ok, c16_ok, crc_step;
  logic [FW-1:0]  fill;
  logic           aligned, flush, check_fail;

  assign recv     = (state_q == ST_RECV);
  assign pid_full = (pid_cnt_q == PID_DONE);
  assign crc_step = dat_vld && pid_full;
  assign aligned  = (fill == '0) || (fill == FILL_MID);
  assign flush    = recv && eop && aligned;

  urx_line_decode #(.RUN(STUFF_RUN)) u_dec (
    .clk(clk), .rst(rst), .restart(eop), .in_vld(bit_vld), .in_lvl(line_lvl),
    .count_en(recv), .raw_bit(raw_bit), .dat_vld(dat_vld), .stuff_err(stuff_err)
  );

  urx_sync_hunt #(.LEN(SYNC_LEN)) u_hunt (
    .clk(clk), .rst(rst), .clr(eop), .en(state_q == ST_HUNT),
    .bit_vld(bit_vld), .bit_in(raw_bit), .found(sync_found)
  );

  urx_crc_serial #(.W(5), .POLY(C5_POLY), .RESID(C5_RESID)) u_crc5 (
    .clk(clk), .rst(rst), .clr(sync_found), .en(crc_step), .bit_in(raw_bit), .ok(c5_ok)
  );

  urx_crc_serial #(.W(16), .POLY(C16_POLY), .RESID(C16_RESID)) u_crc16 (
    .clk(clk), .rst(rst), .clr(sync_found), .en(crc_step), .bit_in(raw_bit), .ok(c16_ok)
  );

  urx_word_pack #(.BW(BYTE_W), .DW(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .clr(sync_found), .bit_vld(dat_vld), .bit_in(raw_bit),
    .flush(flush), .word_q(word_data), .vld_q(word_vld), .half_q(word_half), .fill_q(fill)
  );

  always_comb begin
    check_fail = 1'b0;
    if (crc_en && pid_full) begin
      if (pid_q[1:0] == KIND_TOKEN)     check_fail = !c5_ok;
      else if (pid_q[1:0] == KIND_DATA) check_fail = !c16_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HUNT;
      rx_active <= 1'b0;
      rx_err    <= 1'b0;
      crc_err   <= 1'b0;
      pid_q     <= '0;
      pid_cnt_q <= '0;
    end else begin
      rx_err  <= 1'b0;
      crc_err <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (sync_found) begin
            state_q   <= ST_RECV;
            rx_active <= 1'b1;
            pid_cnt_q <= '0;
          end
        end
        ST_RECV: begin
          if (eop) begin
            state_q   <= ST_HUNT;
            rx_active <= 1'b0;
            if (!aligned) rx_err  <= 1'b1;
            else          crc_err <= check_fail;
          end else if (stuff_err) begin
            state_q   <= ST_DRAIN;
            rx_active <= 1'b0;
            rx_err    <= 1'b1;
          end else if (dat_vld && !pid_full) begin
            pid_q     <= {raw_bit, pid_q[7:1]};
            pid_cnt_q <= pid_cnt_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (eop) state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/usb_rx_deser_chk.sv
module usb_rx_deser_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld,
  input logic eop,
  input logic crc_en,
  input logic rx_active,
  input logic word_vld,
  input logic word_half,
  input logic rx_err,
  input logic crc_err
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(eop && bit_vld));

  p_fall_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |-> ($past(eop) || rx_err));

  p_abort_idle_r4: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> !rx_active);

  p_full_in_pkt_r5: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_half) |-> rx_active);

  p_half_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    word_half |-> (word_vld && !rx_active && $past(eop)));

  p_crc_gate_r9: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> ($past(crc_en) && $past(eop)));

  p_err_split_r10: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> (!rx_err && !rx_active));

  p_crc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    crc_err |=> !crc_err);
endmodule

bind usb_rx_deser usb_rx_deser_chk u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .eop(eop), .crc_en(crc_en),
  .rx_active(rx_active), .word_vld(word_vld), .word_half(word_half),
  .rx_err(rx_err), .crc_err(crc_err)
);

// File: tb/usb_rx_deser_bench.sv
module usb_rx_deser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_vld = 1'b0;
  logic        line_lvl = 1'b1;
  logic        eop = 1'b0;
  logic        crc_en = 1'b0;
  logic        rx_active, word_vld, word_half, rx_err, crc_err;
  logic [15:0] word_data;

  always #2.5 clk = ~clk;

  usb_rx_deser u_usb_rx_deser (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .line_lvl(line_lvl), .eop(eop),
    .crc_en(crc_en), .rx_active(rx_active), .word_vld(word_vld),
    .word_data(word_data), .word_half(word_half), .rx_err(rx_err), .crc_err(crc_err)
  );

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  logic pbits [0:127];
  int   pn;
  logic cur;
  int   gcnt = 0;

  logic [15:0] got_w [0:31];
  logic        got_h [0:31];
  int          got_n, err_n, crc_n;
  bit          seen_act;
  logic        e_rx, e_crc, e_act;

  always @(negedge clk) begin
    if (!rst) begin
      if (word_vld && got_n < 32) begin
        got_w[got_n] = word_data;
        got_h[got_n] = word_half;
        got_n = got_n + 1;
      end
      if (rx_err)    err_n = err_n + 1;
      if (crc_err)   crc_n = crc_n + 1;
      if (rx_active) seen_act = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pk_bit(input logic b);
    pbits[pn] = b;
    pn++;
  endtask

  task automatic pk_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) pk_bit(v[i]);
  endtask

  task automatic pk_crc(input int w);
    logic [15:0] r, poly, mask;
    logic fb;
    mask = (w == 5) ? 16'h001F : 16'hFFFF;
    poly = (w == 5) ? 16'h0005 : 16'h8005;
    r = mask;
    for (int i = 8; i < pn; i++) begin
      fb = pbits[i] ^ r[w-1];
      r = (r << 1) & mask;
      if (fb) r = r ^ poly;
    end
    for (int i = w - 1; i >= 0; i--) pk_bit(~r[i]);
  endtask

  task automatic emit(input logic d);
    if (gcnt % 5 == 4) begin
      @(negedge clk);
      bit_vld = 1'b0;
    end
    gcnt++;
    if (!d) cur = ~cur;
    @(negedge clk);
    bit_vld  = 1'b1;
    line_lvl = cur;
  endtask

  task automatic send_pkt(input bit inject);
    int ones;
    bit inj;
    inj = inject;
    cur = 1'b1;
    repeat (3) emit(1'b1);
    for (int i = 0; i < 7; i++) emit(1'b0);
    emit(1'b1);
    ones = 0;
    for (int i = 0; i < pn; i++) begin
      emit(pbits[i]);
      if (pbits[i]) ones++; else ones = 0;
      if (ones == 6) begin
        emit(inj);
        inj = 1'b0;
        ones = 0;
      end
    end
    @(negedge clk);
    bit_vld = 1'b0;
    line_lvl = 1'b1;
    @(negedge clk);
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    e_rx = rx_err;
    e_crc = crc_err;
    e_act = rx_active;
    cur = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // exp_nw < 0: word count derived from pn
  task automatic run_pkt(input bit inject, input bit en, input bit exp_crc,
                         input int exp_err, input int exp_nw, input string tag);
    int nw, nfull;
    bit half;
    logic [15:0] ew;
    crc_en = en;
    got_n = 0; err_n = 0; crc_n = 0; seen_act = 1'b0;
    send_pkt(inject);
    nfull = pn / 16;
    half = (pn % 16) == 8;
    nw = (exp_nw >= 0) ? exp_nw : nfull + (half ? 1 : 0);
    chk(got_n == nw, {"R5 word count ", tag}, got_n, nw);
    for (int i = 0; i < nw && i < got_n; i++) begin
      ew = '0;
      if (i < nfull) begin
        for (int j = 0; j < 16; j++) ew[j] = pbits[16*i + j];
        chk(got_w[i] == ew && !got_h[i], {"R1 R3 R5 word ", tag}, got_w[i], ew);
      end else begin
        for (int j = 0; j < 8; j++) ew[j] = pbits[16*i + j];
        chk(got_w[i] == ew && got_h[i], {"R6 half word ", tag}, got_w[i], ew);
      end
    end
    chk(seen_act, {"R2 active seen ", tag}, seen_act, 1);
    chk(!e_act, {"R2 active low after end ", tag}, e_act, 0);
    chk(err_n == exp_err, {"R4 R7 rx_err count ", tag}, err_n, exp_err);
    chk(crc_n == int'(exp_crc), {"R8 R9 crc_err count ", tag}, crc_n, exp_crc);
    chk(e_crc == exp_crc, {"R10 crc_err timing ", tag}, e_crc, exp_crc);
    chk(!(e_rx && e_crc), {"R10 exclusive errors ", tag}, {e_rx, e_crc}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11: outputs low during reset
    chk({rx_active, word_vld, word_half, rx_err, crc_err, word_data} == '0,
        "R11 reset outputs", {rx_active, word_vld, rx_err, crc_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rx_active, word_vld, word_half, rx_err, crc_err} == '0,
        "R11 after reset", {rx_active, word_vld, rx_err, crc_err}, 0);

    // Handshake: never checked (R8)
    pn = 0; pk_byte(8'hD2);
    run_pkt(1'b0, 1'b1, 1'b0, 0, -1, "handshake R8");
    pn = 0; pk_byte(8'hD2); pk_byte(8'h00);
    run_pkt(1'b0, 1'b1, 1'b0, 0, -1, "handshake long R8");

    // Tokens: CRC5
    for (int v = 0; v < 16; v++) begin
      for (int en = 0; en < 2; en++) begin
        for (int bad_c = 0; bad_c < 2; bad_c++) begin
          logic [10:0] fld;
          fld = 11'((v * 131 + 7) & 11'h7FF);
          pn = 0;
          pk_byte(8'hE1);
          for (int i = 0; i < 11; i++) pk_bit(fld[i]);
          pk_crc(5);
          if (bad_c != 0) pbits[9] = ~pbits[9];
          run_pkt(1'b0, en[0], en[0] & bad_c[0], 0, -1, "token R8 R9");
        end
      end
    end

    // Data: CRC16 over payload lengths 0..6
    for (int n = 0; n < 7; n++) begin
      for (int en = 0; en < 2; en++) begin
        for (int bad_c = 0; bad_c < 2; bad_c++) begin
          pn = 0;
          pk_byte(8'hC3);
          for (int k = 0; k < n; k++)
            pk_byte((k == 1) ? 8'hFF : 8'((k * 53 + n * 7 + 3) & 8'hFF));
          pk_crc(16);
          if (bad_c != 0) pbits[9] = ~pbits[9];
          run_pkt(1'b0, en[0], en[0] & bad_c[0], 0, -1, "data R3 R8 R9");
        end
      end
    end

    // Long ones run: stuffing across many bytes (R3)
    pn = 0; pk_byte(8'hC3); pk_byte(8'hFF); pk_byte(8'hFF); pk_byte(8'hFF); pk_crc(16);
    run_pkt(1'b0, 1'b1, 1'b0, 0, -1, "ones run R3");

    // Bad stuff bit: abort, no words (R4)
    pn = 0; pk_byte(8'hC3); pk_byte(8'hFF); pk_byte(8'hFF); pk_crc(16);
    run_pkt(1'b1, 1'b1, 1'b0, 1, 0, "stuff error R4");

    // Stop off the byte boundary (R7)
    pn = 0; pk_byte(8'hC3); pk_bit(1'b1); pk_bit(1'b0); pk_bit(1'b1);
    run_pkt(1'b0, 1'b1, 1'b0, 1, 0, "misaligned short R7");
    pn = 0; pk_byte(8'hC3); pk_byte(8'h5A);
    for (int i = 0; i < 5; i++) pk_bit(i[0]);
    run_pkt(1'b0, 1'b1, 1'b0, 1, 1, "misaligned long R7");

    // Recovery after error
    pn = 0; pk_byte(8'hE1); for (int i = 0; i < 11; i++) pk_bit(1'b0); pk_crc(5);
    run_pkt(1'b0, 1'b1, 1'b0, 0, -1, "token after error R2");

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule